// File: doc/BRIEF.md
# Pulse-Distance Command Transmitter

This block turns an 8-bit command from a host into a serial pulse-distance code for a two-wire external control input. Each command becomes an 11-bit frame: a fixed 3-bit header followed by the command, most significant bit first. Every bit starts with a burst of a fixed number of carrier cycles. The distance from one burst start to the next gives the bit value, and a long distance means 1. One extra burst closes the frame so that the last gap is bounded. The output line is low whenever no burst is being sent.

The host hands over commands through a valid/ready pair. The block raises `cmd_ready` only while idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While a frame is in flight, `cmd_ready` stays low and back-pressures the source. A source that drops `cmd_valid` before `cmd_ready` returns has its offer discarded without effect. When the closing burst ends, `frame_done` rises and stays high until the next command is accepted. The host polls this flag to learn when it may send again.

All timing comes from the system clock parameter. The carrier half period is `CLK_HZ/(2*CARRIER_HZ)` clocks. One timing unit equals one burst, which is `BURST_CYCLES` carrier periods. A 0 bit spans `ZERO_UNITS` units and a 1 bit spans `ONE_UNITS` units. With the defaults (38 kHz carrier, 10-cycle bursts, 4 and 8 units) the bit periods are about 1.05 ms and 2.10 ms.

Top module: `pdx_cmd_tx`

## Requirements
- R1: While reset is asserted, `tx_out` is 0, `cmd_ready` is 1 and `frame_done` is 0.
- R2: A command is accepted on a rising clock edge where `cmd_valid` and `cmd_ready` are both 1. From the next cycle, `cmd_ready` is 0 until the frame ends. A `cmd_valid` pulse while `cmd_ready` is 0 is ignored: the frame in flight is unchanged and no further frame follows.
- R3: The frame has 11 bits: the 3-bit `HEADER` parameter (default 3'b101) first, then `cmd_data` bit 7 down to bit 0.
- R4: Each burst is exactly `BURST_CYCLES` carrier periods. In each period `tx_out` is high for H clocks and then low for H clocks, where H = `CLK_HZ/(2*CARRIER_HZ)`. The first high of a frame begins in the first cycle after acceptance.
- R5: Let U = `BURST_CYCLES`*2*H clocks. The distance from the start of a bit's burst to the start of the next burst is `ZERO_UNITS`*U for a 0 and `ONE_UNITS`*U for a 1.
- R6: After the 11th bit period, one more burst of `BURST_CYCLES` carrier periods is sent. No burst follows it.
- R7: `frame_done` rises in the first cycle after the closing burst ends. That cycle comes exactly (sum of the 11 bit periods + U) cycles after the first high. `cmd_ready` returns to 1 in the same cycle. `frame_done` stays high until the next acceptance and is 0 in the cycle after it.
- R8: `tx_out` is 0 in every idle cycle and in every gap between bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency `CLK_HZ` |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Host offers a command |
| cmd_ready | output | 1 | Block is idle and will take a command |
| cmd_data | input | 8 | Command byte, read on acceptance |
| tx_out | output | 1 | Modulated output line, idles low |
| frame_done | output | 1 | End-of-transmission flag, held until next acceptance |

## Verification
Commands 8'h00 and 8'hFF make every command bit short or every bit long, so the two spacings are each measured alone. The alternating and mixed patterns (8'hA5, 8'h3C, 8'h96, 8'h01, 8'h80) catch errors in bit order, in shift direction and in switching between spacings. A monitor rebuilds each bit from the distance between burst starts, counts carrier cycles in every burst including the closing one, and times `frame_done` against the frame length computed from the requirements. An offer made while busy, followed by a long idle wait, shows that the offer leaves no trace. Back-to-back commands check that the done flag clears and that a new frame starts on time.

// File: rtl/pdx_pkg.sv
package pdx_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BIT  = 2'd1,
    SEQ_TAIL = 2'd2
  } seq_state_t;

  // Counter width able to hold values 0 .. depth-1 (at least one bit).
  function automatic int cnt_width(input int unsigned depth);
    return (depth <= 1) ? 1 : $clog2(depth);
  endfunction

endpackage

// File: rtl/pdx_carrier.sv
// Carrier phase generator: high for HALF_CLKS clocks, then low for HALF_CLKS.
// Restarts at phase zero whenever run is low.
module pdx_carrier #(
  parameter int unsigned HALF_CLKS = 657
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic carrier_hi,
  output logic period_end
);
  localparam int unsigned PERIOD_CLKS = 2 * HALF_CLKS;
  localparam int unsigned PW = pdx_pkg::cnt_width(PERIOD_CLKS);
  localparam logic [PW-1:0] PH_LAST = PW'(PERIOD_CLKS - 1);
  localparam logic [PW-1:0] PH_HALF = PW'(HALF_CLKS);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!run || phase_q == PH_LAST) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign carrier_hi = run && (phase_q < PH_HALF);
  assign period_end = run && (phase_q == PH_LAST);

endmodule

// File: rtl/pdx_frame_shift.sv
// Frame register: loads {HEADER, cmd} and moves one place toward the MSB per bit.
module pdx_frame_shift #(
  parameter int unsigned CMD_W = 8,
  parameter int unsigned HDR_W = 3,
  parameter logic [HDR_W-1:0] HEADER = 3'b101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CMD_W-1:0] cmd,
  input  logic             advance,
  output logic             cur_bit
);
  localparam int unsigned FRAME_W = HDR_W + CMD_W;

  logic [FRAME_W-1:0] image;
  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_d;

  assign image = {HEADER, cmd};

  generate
    for (genvar i = 0; i < FRAME_W; i++) begin : g_cell
      if (i == 0) begin : g_lsb
        assign sr_d[i] = load ? image[i] : (advance ? 1'b0 : sr_q[i]);
      end else begin : g_upper
        assign sr_d[i] = load ? image[i] : (advance ? sr_q[i-1] : sr_q[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign cur_bit = sr_q[FRAME_W-1];

endmodule

// File: rtl/pdx_seq.sv
// Frame sequencer: counts carrier periods into units, units into bit periods,
// bit periods into a frame, then sends the closing burst.
module pdx_seq #(
  parameter int unsigned BURST_CYCLES = 10,
  parameter int unsigned ZERO_UNITS   = 4,
  parameter int unsigned ONE_UNITS    = 8,
  parameter int unsigned FRAME_W      = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic period_end,
  input  logic cur_bit,
  output logic busy,
  output logic in_burst,
  output logic advance,
  output logic done_flag
);
  import pdx_pkg::*;

  localparam int unsigned MAX_UNITS = (ONE_UNITS > ZERO_UNITS) ? ONE_UNITS : ZERO_UNITS;
  localparam int unsigned CW = cnt_width(BURST_CYCLES);
  localparam int unsigned UW = cnt_width(MAX_UNITS);
  localparam int unsigned BW = cnt_width(FRAME_W);
  localparam logic [CW-1:0] CYC_LAST  = CW'(BURST_CYCLES - 1);
  localparam logic [UW-1:0] ZERO_LAST = UW'(ZERO_UNITS - 1);
  localparam logic [UW-1:0] ONE_LAST  = UW'(ONE_UNITS - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_W - 1);

  seq_state_t    st_q;
  logic [CW-1:0] cyc_q;
  logic [UW-1:0] unit_q;
  logic [BW-1:0] bit_q;
  logic          done_q;

  logic          unit_end;
  logic [UW-1:0] units_last;
  logic          bit_end;

  assign unit_end   = period_end && (cyc_q == CYC_LAST);
  assign units_last = cur_bit ? ONE_LAST : ZERO_LAST;
  assign bit_end    = (st_q == SEQ_BIT) && unit_end && (unit_q == units_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      cyc_q  <= '0;
      unit_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      case (st_q)
        SEQ_IDLE: begin
          if (start) begin
            st_q   <= SEQ_BIT;
            cyc_q  <= '0;
            unit_q <= '0;
            bit_q  <= '0;
            done_q <= 1'b0;
          end
        end
        SEQ_BIT: begin
          if (period_end) begin
            cyc_q <= unit_end ? '0 : cyc_q + 1'b1;
          end
          if (bit_end) begin
            unit_q <= '0;
            if (bit_q == BIT_LAST) begin
              st_q <= SEQ_TAIL;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end else if (unit_end) begin
            unit_q <= unit_q + 1'b1;
          end
        end
        SEQ_TAIL: begin
          if (period_end) begin
            cyc_q <= unit_end ? '0 : cyc_q + 1'b1;
          end
          if (unit_end) begin
            st_q   <= SEQ_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != SEQ_IDLE);
  assign in_burst  = ((st_q == SEQ_BIT) && (unit_q == '0)) || (st_q == SEQ_TAIL);
  assign advance   = bit_end;
  assign done_flag = done_q;

endmodule

// File: rtl/pdx_cmd_tx.sv
module pdx_cmd_tx #(
  parameter int unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned CARRIER_HZ   = 38_000,
  parameter int unsigned BURST_CYCLES = 10,
  parameter int unsigned ZERO_UNITS   = 4,
  parameter int unsigned ONE_UNITS    = 8,
  parameter int unsigned CMD_W        = 8,
  parameter int unsigned HDR_W        = 3,
  parameter logic [HDR_W-1:0] HEADER  = 3'b101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CMD_W-1:0] cmd_data,
  output logic             tx_out,
  output logic             frame_done
);
  localparam int unsigned HALF_CLKS = CLK_HZ / (2 * CARRIER_HZ);
  localparam int unsigned FRAME_W   = HDR_W + CMD_W;

  logic busy;
  logic accept;
  logic carrier_hi;
  logic period_end;
  logic cur_bit;
  logic advance;
  logic in_burst;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;

  pdx_carrier #(
    .HALF_CLKS(HALF_CLKS)
  ) u_carrier (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .carrier_hi(carrier_hi),
    .period_end(period_end)
  );

  pdx_frame_shift #(
    .CMD_W (CMD_W),
    .HDR_W (HDR_W),
    .HEADER(HEADER)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .cmd    (cmd_data),
    .advance(advance),
    .cur_bit(cur_bit)
  );

  pdx_seq #(
    .BURST_CYCLES(BURST_CYCLES),
    .ZERO_UNITS  (ZERO_UNITS),
    .ONE_UNITS   (ONE_UNITS),
    .FRAME_W     (FRAME_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .period_end(period_end),
    .cur_bit   (cur_bit),
    .busy      (busy),
    .in_burst  (in_burst),
    .advance   (advance),
    .done_flag (frame_done)
  );

  assign tx_out = in_burst && carrier_hi;

endmodule

// File: rtl/pdx_cmd_tx_chk.sv
module pdx_cmd_tx_chk #(
  parameter int unsigned HALF_CLKS = 657
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic tx_out,
  input logic frame_done
);
  int unsigned hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= 0;
    end else begin
      hi_run <= tx_out ? hi_run + 1 : 0;
    end
  end

  // R8: idle line stays low
  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !tx_out);

  // R2 and R4: acceptance drops ready and starts the first high
  p_accept_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!cmd_ready && tx_out));

  // R7: acceptance clears the done flag
  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !frame_done);

  // R7: done flag only while idle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> cmd_ready);

  // R6: every frame end raises the done flag
  p_end_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_ready) |-> frame_done);

  // R7: done flag holds without a new offer
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !cmd_valid) |=> frame_done);

  // R4: carrier high half is exactly HALF_CLKS
  p_high_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_out) |-> (hi_run == HALF_CLKS));

  // R4: no high run longer than a half period
  p_high_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= HALF_CLKS);

endmodule

bind pdx_cmd_tx pdx_cmd_tx_chk #(
  .HALF_CLKS(HALF_CLKS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .tx_out    (tx_out),
  .frame_done(frame_done)
);

// File: tb/test_pdx_cmd_tx.sv
module test_pdx_cmd_tx;
  localparam int CLK_HZ = 228_000;
  localparam int CARRIER_HZ = 38_000;
  localparam int BURST = 10;
  localparam int ZU = 4;
  localparam int OU = 8;
  localparam int H = CLK_HZ / (2 * CARRIER_HZ);
  localparam int U = BURST * 2 * H;
  localparam logic [2:0] HDR = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic cmd_ready, tx_out, frame_done;

  always #10 clk = ~clk;

  pdx_cmd_tx #(
    .CLK_HZ(CLK_HZ), .CARRIER_HZ(CARRIER_HZ), .BURST_CYCLES(BURST),
    .ZERO_UNITS(ZU), .ONE_UNITS(OU), .CMD_W(8), .HDR_W(3), .HEADER(HDR)
  ) i_pdx_cmd_tx (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .tx_out(tx_out), .frame_done(frame_done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit q_bits[$];
  int q_tot[$];

  int cyc = 0, t0 = 0, exp_start = 0, last_start = 0;
  bit exp_armed = 0, accept_seen = 0, prev_tx = 0, prev_done = 0;
  int low_run = 1000, hi_run = 0, pulses = 0, burst_idx = 0, frames_done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: rebuilds bits from burst spacing, pops scoreboard entries
  always @(negedge clk) begin
    int d, got, expb, tot;
    if (rst_n) begin
      cyc++;
      if (accept_seen) begin
        accept_seen = 0;
        check(!cmd_ready, "R2", "ready after accept", cmd_ready, 0);
        check(!frame_done, "R7", "done after accept", frame_done, 0);
      end
      if (cmd_valid && cmd_ready) begin
        accept_seen = 1;
        exp_start = cyc + 1;
        exp_armed = 1;
      end
      if (tx_out && !prev_tx) begin
        if (burst_idx == 0) begin
          check(exp_armed, "R2", "burst without accepted command", 1, 0);
          check(cyc == exp_start, "R4", "first high cycle", cyc, exp_start);
          exp_armed = 0;
          t0 = cyc;
          burst_idx = 1;
          pulses = 1;
          last_start = cyc;
        end else if (low_run > H) begin
          check(pulses == BURST, "R4", "carrier cycles per burst", pulses, BURST);
          if (burst_idx <= 11) begin
            d = cyc - last_start;
            got = (d == ZU * U) ? 0 : (d == OU * U) ? 1 : 2;
            check(got != 2, "R5", "burst spacing", d, ZU * U);
            expb = (q_bits.size() > 0) ? int'(q_bits.pop_front()) : 3;
            check(got == expb, "R3", "decoded bit", got, expb);
          end else begin
            check(0, "R6", "burst after closing burst", burst_idx, 11);
          end
          burst_idx++;
          pulses = 1;
          last_start = cyc;
        end else begin
          pulses++;
          check(low_run == H, "R4", "carrier low half", low_run, H);
        end
      end
      if (!tx_out && prev_tx) begin
        check(hi_run == H, "R4", "carrier high half", hi_run, H);
      end
      if (tx_out) hi_run = prev_tx ? hi_run + 1 : 1;
      else low_run = prev_tx ? 1 : low_run + 1;
      if (frame_done && !prev_done) begin
        check(burst_idx == 12, "R6", "bursts in frame", burst_idx, 12);
        check(pulses == BURST, "R6", "closing burst carrier cycles", pulses, BURST);
        tot = (q_tot.size() > 0) ? q_tot.pop_front() : -1;
        check(cyc == t0 + tot, "R7", "done flag cycle", cyc, t0 + tot);
        check(cmd_ready, "R7", "ready with done", cmd_ready, 1);
        burst_idx = 0;
        frames_done++;
      end
      prev_tx = tx_out;
      prev_done = frame_done;
    end
  end

  // Driver: pushes expected bits and frame length, then offers the command
  task automatic send(input logic [7:0] cmd);
    logic [10:0] f;
    int tot;
    f = {HDR, cmd};
    tot = U;
    for (int i = 10; i >= 0; i--) begin
      q_bits.push_back(f[i]);
      tot += (f[i] ? OU : ZU) * U;
    end
    q_tot.push_back(tot);
    @(posedge clk); #1;
    while (!cmd_ready) begin
      @(posedge clk); #1;
    end
    cmd_valid = 1'b1;
    cmd_data = cmd;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    cmd_data = 8'h00;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d frames", frames_done, 7);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(tx_out == 0, "R1", "tx_out in reset", tx_out, 0);
    check(cmd_ready == 1, "R1", "ready in reset", cmd_ready, 1);
    check(frame_done == 0, "R1", "done in reset", frame_done, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    send(8'hA5); wait (frames_done == 1);
    send(8'h00); wait (frames_done == 2);
    send(8'hFF); wait (frames_done == 3);
    send(8'h3C); wait (frames_done == 4);

    // R2: offer while busy must leave no trace
    send(8'h96);
    repeat (200) @(posedge clk);
    #1;
    check(cmd_ready == 0, "R2", "ready while busy", cmd_ready, 0);
    cmd_valid = 1'b1;
    cmd_data = 8'h00;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    wait (frames_done == 5);
    repeat (600) @(negedge clk);
    check(burst_idx == 0, "R2", "no frame from ignored offer", burst_idx, 0);
    check(tx_out == 0, "R8", "idle line", tx_out, 0);
    check(frame_done == 1, "R7", "done held while idle", frame_done, 1);
    check(cmd_ready == 1, "R7", "ready held while idle", cmd_ready, 1);

    // back-to-back
    send(8'h01); wait (frames_done == 6);
    send(8'h80); wait (frames_done == 7);
    repeat (20) @(negedge clk);
    check(q_bits.size() == 0, "R3", "bits left in scoreboard", q_bits.size(), 0);
    summary();
    $finish;
  end
endmodule